// File: doc/BRIEF.md
# Dual-Mailbox Memory-Mapped Bridge

This block connects a processor's asynchronous external memory bus to logic running on a local clock. The processor side has a 16-bit bidirectional data bus, eight address lines, and active-low chip-select, read and write strobes. Two 128-word by 16-bit mailbox RAMs sit behind one 256-word address window, one RAM for each direction.

The processor posts words into the inbound mailbox, and the local logic reads them through its own read port. The local logic writes words into the outbound mailbox, and the processor reads them back over the bus. Write rights are enforced in hardware. A processor write aimed at the outbound mailbox is dropped. A processor read aimed at the inbound mailbox returns zero.

The chip-select and write strobe are brought into the local clock domain through two-flop synchronisers. A processor write is committed on the rising edge of the synchronised write qualifier, using the address and data present on the bus in that cycle.

Top module: `mbox_bridge`

## Requirements
- R1: While `rst` is high, no processor write is committed, even when chip-select and the write strobe are both active.
- R2: Address bit 7 picks the mailbox (0 = inbound, processor-to-logic; 1 = outbound, logic-to-processor). Bits 6:0 pick the word, and all 128 words of each mailbox, including index 0 and index 127, are reachable.
- R3: A processor write (chip-select and write strobe low) to an address with bit 7 = 0 stores the 16-bit bus data in the inbound mailbox at index bits 6:0.
- R4: A processor write to an address with bit 7 = 1 changes neither mailbox.
- R5: A processor read of an address with bit 7 = 0 returns 0x0000 on the data bus.
- R6: A local write (`lcl_wr_en` high at a rising clock edge) stores `lcl_wr_data` in the outbound mailbox at `lcl_wr_addr`, and the processor can read it back at address 0x80 + index.
- R7: A write is committed only after the strobes have passed through two synchroniser flops, exactly once per strobe assertion, and never while chip-select is inactive.
- R8: The block drives `bus_data` only while both `bus_cs_n` and `bus_rd_n` are low. At all other times it leaves the bus undriven.
- R9: `lcl_rd_data` shows the inbound mailbox word at the `lcl_rd_addr` value sampled on the previous rising clock edge.
- R10: During a processor read, the data bus carries the addressed word from the first rising clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Processor chip-select, active low |
| bus_rd_n | input | 1 | Processor read strobe, active low |
| bus_wr_n | input | 1 | Processor write strobe, active low |
| bus_addr | input | 8 | Processor word address; bit 7 selects the mailbox |
| bus_data | inout | 16 | Processor data bus, driven by the block only during reads |
| lcl_rd_addr | input | 7 | Local read index into the inbound mailbox |
| lcl_rd_data | output | 16 | Registered inbound mailbox word |
| lcl_wr_en | input | 1 | Local write enable for the outbound mailbox |
| lcl_wr_addr | input | 7 | Local write index into the outbound mailbox |
| lcl_wr_data | input | 16 | Local write data |

## Verification
Some internal faults corrupt mailbox contents. A synchroniser edge detector stuck high, a mailbox select bit inverted, or a missing write guard each leave a wrong word in a RAM. None of these faults shows up until that word is read back: through the local port one clock after the index is applied, or on the bus one clock after a processor read starts. The bench therefore reads back every location it writes, including locations it tried and failed to write, and locations written while reset was held. A wrong read-path select shows up within one clock of the read as a non-zero value or a wrong word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Mailbox selected by the top address bit
  typedef enum logic {
    MBOX_IN  = 1'b0,  // processor -> local logic
    MBOX_OUT = 1'b1   // local logic -> processor
  } mbox_dir_e;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [AW-1:0] bus_addr,
  inout  wire  [DW-1:0] bus_data,
  input  logic [AW-2:0] lcl_rd_addr,
  output logic [DW-1:0] lcl_rd_data,
  input  logic          lcl_wr_en,
  input  logic [AW-2:0] lcl_wr_addr,
  input  logic [DW-1:0] lcl_wr_data
);
  import mbox_pkg::*;

  localparam int unsigned IW = AW - 1;  // word index width per mailbox

  // ---------------- write path: synchronise strobes ----------------
  logic [1:0] strb_s;     // [1] = cs_n, [0] = wr_n, synchronised
  logic       wr_act_s;
  logic       wr_act_q;
  logic       wr_pulse;
  logic       p2l_we;
  mbox_dir_e  wr_dir;

  mbox_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) i_strb_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_cs_n, bus_wr_n}),
    .q   (strb_s)
  );

  assign wr_act_s = ~strb_s[1] & ~strb_s[0];

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act_s;
  end

  assign wr_pulse = wr_act_s & ~wr_act_q;
  assign wr_dir   = mbox_dir_e'(bus_addr[AW-1]);
  assign p2l_we   = wr_pulse & (wr_dir == MBOX_IN) & ~rst;

  // Inbound mailbox: processor writes, local logic reads
  mbox_ram #(.AW(IW), .DW(DW)) i_ram_in (
    .clk   (clk),
    .we    (p2l_we),
    .waddr (bus_addr[IW-1:0]),
    .wdata (bus_data),
    .raddr (lcl_rd_addr),
    .rdata (lcl_rd_data)
  );

  // ---------------- read path ----------------
  logic [DW-1:0] out_rdata;
  logic          rd_sel_q;
  logic [DW-1:0] rd_word;
  logic          bus_oe;

  // Outbound mailbox: local logic writes, processor reads
  mbox_ram #(.AW(IW), .DW(DW)) i_ram_out (
    .clk   (clk),
    .we    (lcl_wr_en),
    .waddr (lcl_wr_addr),
    .wdata (lcl_wr_data),
    .raddr (bus_addr[IW-1:0]),
    .rdata (out_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= 1'b0;
    else     rd_sel_q <= bus_addr[AW-1];
  end

  assign rd_word  = (mbox_dir_e'(rd_sel_q) == MBOX_OUT) ? out_rdata : '0;
  assign bus_oe   = ~bus_cs_n & ~bus_rd_n;
  assign bus_data = bus_oe ? rd_word : {DW{1'bz}};
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_cs_n,
  input logic          bus_wr_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] rd_word,
  input logic          wr_act_s,
  input logic          p2l_we
);
  // R5: a read of the inbound half yields zero one clock later
  a_r5_in_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_addr[AW-1]) |-> (rd_word == '0));

  // R7: a commit needs strobes seen two clocks earlier at the pins
  a_r7_commit_after_sync: assert property (@(posedge clk) disable iff (rst)
    p2l_we |-> $past(!bus_cs_n && !bus_wr_n, 2));

  // R7: one commit per strobe assertion
  a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
    p2l_we |=> !p2l_we);

  // R7: synchronised qualifier rises two clocks after the pins
  a_r7_sync_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_act_s) |-> $past(!bus_cs_n && !bus_wr_n, 2));
endmodule

bind mbox_bridge mbox_bridge_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_cs_n (bus_cs_n),
  .bus_wr_n (bus_wr_n),
  .bus_addr (bus_addr),
  .rd_word  (rd_word),
  .wr_act_s (wr_act_s),
  .p2l_we   (p2l_we)
);

// File: tb/test_mbox_bridge.sv
`timescale 1ns/1ps
module test_mbox_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1;
  logic        bus_rd_n = 1'b1;
  logic        bus_wr_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  wire  [15:0] bus_data;
  logic [6:0]  lcl_rd_addr = '0;
  logic [15:0] lcl_rd_data;
  logic        lcl_wr_en = 1'b0;
  logic [6:0]  lcl_wr_addr = '0;
  logic [15:0] lcl_wr_data = '0;

  logic        tb_drv_en = 1'b0;
  logic [15:0] tb_drv_val = '0;
  assign bus_data = tb_drv_en ? tb_drv_val : 16'hzzzz;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Behavioural reference: contents of both mailboxes
  int in_model  [int];
  int out_model [int];

  always #2.5 clk = ~clk;  // 200 MHz

  mbox_bridge i_mbox_bridge (
    .clk(clk), .rst(rst),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .lcl_rd_addr(lcl_rd_addr), .lcl_rd_data(lcl_rd_data),
    .lcl_wr_en(lcl_wr_en), .lcl_wr_addr(lcl_wr_addr), .lcl_wr_data(lcl_wr_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [15:0] d, input bit use_cs);
    @(negedge clk);
    bus_addr = a; tb_drv_val = d; tb_drv_en = 1'b1;
    bus_cs_n = !use_cs; bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    @(negedge clk);
    tb_drv_en = 1'b0;
    repeat (3) @(negedge clk);
    if (use_cs && !rst && a[7] == 1'b0) in_model[int'(a[6:0])] = int'(d);
  endtask

  task automatic cpu_read(input logic [7:0] a, input string req);
    logic [15:0] exp;
    @(negedge clk);
    bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    @(negedge clk);  // R10: valid after one rising edge
    if (a[7]) exp = out_model.exists(int'(a[6:0])) ? 16'(out_model[int'(a[6:0])]) : 16'hxxxx;
    else      exp = 16'h0000;
    check(req, bus_data, exp);
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
  endtask

  task automatic lcl_write(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    lcl_wr_en = 1'b1; lcl_wr_addr = a; lcl_wr_data = d;
    @(negedge clk);
    lcl_wr_en = 1'b0;
    out_model[int'(a)] = int'(d);
  endtask

  task automatic lcl_read(input logic [6:0] a, input string req);
    @(negedge clk);
    lcl_rd_addr = a;
    @(negedge clk);  // R9: one-clock latency
    check(req, lcl_rd_data, 16'(in_model[int'(a)]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R8: idle bus is left to the other driver
    tb_drv_en = 1'b1; tb_drv_val = 16'hA5C3; bus_cs_n = 1'b0;
    @(negedge clk);
    check("R8 idle rd_n high", bus_data, 16'hA5C3);
    bus_cs_n = 1'b1; bus_rd_n = 1'b0;
    @(negedge clk);
    check("R8 idle cs_n high", bus_data, 16'hA5C3);
    bus_rd_n = 1'b1; tb_drv_en = 1'b0;

    // R3 / R2: inbound writes incl. index 0 and 127
    cpu_write(8'h00, 16'h1234, 1'b1);
    cpu_write(8'h7F, 16'hFFFF, 1'b1);
    cpu_write(8'h2A, 16'h0001, 1'b1);
    cpu_write(8'h03, 16'h1111, 1'b1);
    lcl_read(7'h00, "R3 R2 index 0");
    lcl_read(7'h7F, "R3 R2 index 127");
    lcl_read(7'h2A, "R3 mid index");

    // R9: back-to-back local reads, one clock apart
    @(negedge clk); lcl_rd_addr = 7'h7F;
    @(negedge clk); check("R9 b2b first", lcl_rd_data, 16'hFFFF); lcl_rd_addr = 7'h00;
    @(negedge clk); check("R9 b2b second", lcl_rd_data, 16'h1234);

    // R6 / R2 / R10: outbound through local port, read by processor
    lcl_write(7'h00, 16'hBEEF);
    lcl_write(7'h7F, 16'h8001);
    cpu_read(8'h80, "R6 R10 out index 0");
    cpu_read(8'hFF, "R6 R2 out index 127");

    // R4: processor write to outbound half is dropped
    cpu_write(8'h80, 16'h0BAD, 1'b1);
    cpu_read(8'h80, "R4 out unchanged");
    lcl_read(7'h00, "R4 in not aliased");

    // R5: inbound half reads as zero
    cpu_read(8'h00, "R5 in reads zero");
    cpu_read(8'h7F, "R5 in reads zero 127");

    // R7: write strobe without chip-select
    cpu_write(8'h2A, 16'h7777, 1'b0);
    lcl_read(7'h2A, "R7 no chip-select");

    // R7: long strobe commits once with the same data
    cpu_write(8'h55, 16'h5A5A, 1'b1);
    lcl_read(7'h55, "R7 commit");

    // R1: write attempted while reset is held
    @(negedge clk); rst = 1'b1;
    cpu_write(8'h03, 16'h2222, 1'b1);
    repeat (2) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    lcl_read(7'h03, "R1 no commit in reset");

    // R8: driven during read (value also checked above)
    cpu_read(8'hFF, "R8 driven on read");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule